// File: doc/BRIEF.md
# Multichannel Ultrasound Burst Generator

This block produces three-level drive codes for four transducer channels. Each code means positive, negative or ground. Each channel has three output stages. The first stage carries an optional half-pulse prelude. The second stage carries the pulsed burst. The third stage carries continuous-wave drive.

Each channel has its own settings: a half-period length in clock cycles, a number of full pulses, a number of prelude half pulses, a flag that makes the first half negative, a continuous flag and a two-stage flag. One repetition interval, given in cycles, is shared by all channels. A full pulse therefore lasts an even number of cycles.

A start pulse launches every channel on the same clock edge, so the phase relationships between channels are exact. A counter-phase pair is two channels with the same settings and opposite first polarity. Pulsed channels restart at every repetition boundary. Continuous channels run without gaps until a stop pulse arrives. Configuration inputs must be held steady while the block is running.

Top module: `us_burst_gen`

## Requirements
- R1: Every stage output is a 2-bit code: 00 means ground, 01 means positive and 10 means negative. The code 11 never appears.
- R2: When `start` is sampled high while the block is idle and `stop` is low, every channel shows its first half-period on the next cycle, and all channels begin on that same cycle.
- R3: Each half-period lasts `half_len` cycles, and a full pulse is two half-periods. The polarity alternates from one half to the next. The first half is positive when the channel's `neg_first` bit is 0 and negative when it is 1.
- R4: In pulsed mode, the main stage shows 2×`burst_len` half-periods from the start of each repetition frame. After that it shows ground until the frame ends.
- R5: A repetition frame lasts `rep_len` cycles. Every pulsed channel restarts its sequence at each frame boundary, and a sequence that has not finished by then is cut off there.
- R6: In two-stage mode, the prelude stage first shows `pre_len` half-periods, with alternating polarity from the initial polarity. The main stage then shows its burst, starting again from the initial polarity. When `pre_len` is 0 the prelude is skipped.
- R7: A channel in continuous mode alternates its continuous stage every `half_len` cycles and ignores frame boundaries. It drives nothing on its other two stages.
- R8: After reset, and from the cycle after `stop` is sampled high, every stage of every channel shows ground until the next accepted start.
- R9: Two channels with identical settings and opposite `neg_first` show opposite non-ground codes on every cycle.
- R10: A `start` sampled while the block is running has no effect on the outputs. When `start` and `stop` are high in the same cycle, `stop` wins.
- R11: At any cycle, at most one stage of a channel shows a non-ground code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch all channels |
| stop | input | 1 | Halt all channels and return them to ground |
| rep_len | input | RW | Repetition interval in cycles, shared by all channels |
| half_len | input | NCH*HW | Per-channel half-period in cycles (nonzero) |
| burst_len | input | NCH*PW | Per-channel count of full pulses on the main stage |
| pre_len | input | NCH*QW | Per-channel count of prelude half pulses |
| neg_first | input | NCH | Per-channel flag: first half is negative |
| cont_en | input | NCH | Per-channel flag: continuous mode |
| two_stage | input | NCH | Per-channel flag: enable the prelude stage |
| drv_pre | output | 2*NCH | Prelude stage codes, 2 bits per channel |
| drv_main | output | 2*NCH | Main burst stage codes, 2 bits per channel |
| drv_cw | output | 2*NCH | Continuous stage codes, 2 bits per channel |
| active | output | 1 | High while the generator is running |

## Verification
Two pairs of events can land in the same cycle.

The first pair is a start and a stop. The bench raises both on the same clock edge while bursts are running, then expects ground on every stage for the following cycles. That shows stop wins and no relaunch takes place.

The second pair is a frame boundary and a half-period that is still in progress. One channel is set up with a burst longer than the repetition interval, so the boundary arrives mid-burst. The bench expects that channel to restart at its initial polarity at the exact boundary cycle, while the other channels, whose bursts have finished, restart on the same cycle.

// File: rtl/us_burst_gen.sv
module us_burst_gen #(
  parameter int NCH = 4,
  parameter int HW  = 8,
  parameter int PW  = 8,
  parameter int QW  = 4,
  parameter int RW  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              stop,
  input  logic [RW-1:0]     rep_len,
  input  logic [NCH*HW-1:0] half_len,
  input  logic [NCH*PW-1:0] burst_len,
  input  logic [NCH*QW-1:0] pre_len,
  input  logic [NCH-1:0]    neg_first,
  input  logic [NCH-1:0]    cont_en,
  input  logic [NCH-1:0]    two_stage,
  output logic [2*NCH-1:0]  drv_pre,
  output logic [2*NCH-1:0]  drv_main,
  output logic [2*NCH-1:0]  drv_cw,
  output logic              active
);
  localparam int IW = PW + 2;
  localparam logic [1:0] C_GND = 2'b00;
  localparam logic [1:0] C_POS = 2'b01;
  localparam logic [1:0] C_NEG = 2'b10;

  typedef enum logic [1:0] {S_PRE, S_MAIN, S_DONE} stg_t;

  logic          run;
  logic [RW-1:0] frame;

  wire launch = start && !stop && !run;
  wire wrap   = run && (frame == rep_len - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= 1'b0;
      frame <= '0;
    end else if (stop) begin
      run   <= 1'b0;
      frame <= '0;
    end else if (launch) begin
      run   <= 1'b1;
      frame <= '0;
    end else if (run) begin
      frame <= wrap ? '0 : frame + 1'b1;
    end
  end

  assign active = run;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    wire [HW-1:0] h   = half_len[c*HW +: HW];
    wire [PW-1:0] b   = burst_len[c*PW +: PW];
    wire [QW-1:0] p   = pre_len[c*QW +: QW];
    wire          cnt = cont_en[c];

    logic [HW-1:0] hc;
    logic [IW-1:0] hi;
    stg_t          st;
    stg_t          first;

    wire [IW-1:0] main_last = {1'b0, b, 1'b0} - 1'b1;
    wire [IW-1:0] pre_last  = {{(IW-QW){1'b0}}, p} - 1'b1;
    wire          half_end  = (hc == h - 1'b1);

    always_comb begin
      if (cnt)                        first = S_MAIN;
      else if (two_stage[c] && p != 0) first = S_PRE;
      else if (b != 0)                first = S_MAIN;
      else                            first = S_DONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hc <= '0;
        hi <= '0;
        st <= S_DONE;
      end else if (launch || (wrap && !stop && !cnt)) begin
        hc <= '0;
        hi <= '0;
        st <= first;
      end else if (run && st != S_DONE) begin
        if (half_end) begin
          hc <= '0;
          if (!cnt && st == S_PRE && hi == pre_last) begin
            hi <= '0;
            st <= (b != 0) ? S_MAIN : S_DONE;
          end else if (!cnt && st == S_MAIN && hi == main_last) begin
            st <= S_DONE;
          end else begin
            hi <= hi + 1'b1;
          end
        end else begin
          hc <= hc + 1'b1;
        end
      end
    end

    wire [1:0] code = (hi[0] ^ neg_first[c]) ? C_NEG : C_POS;

    assign drv_pre[2*c +: 2]  = (run && !cnt && st == S_PRE)  ? code : C_GND;
    assign drv_main[2*c +: 2] = (run && !cnt && st == S_MAIN) ? code : C_GND;
    assign drv_cw[2*c +: 2]   = (run &&  cnt && st == S_MAIN) ? code : C_GND;

    // R1
    code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drv_pre[2*c +: 2] != 2'b11 && drv_main[2*c +: 2] != 2'b11 && drv_cw[2*c +: 2] != 2'b11);

    // R11
    one_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({|drv_pre[2*c +: 2], |drv_main[2*c +: 2], |drv_cw[2*c +: 2]}));

    // R3
    half_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && st != S_DONE && h != 0) |-> hc < h);
  end

  // R8
  stop_ground_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (drv_pre == '0 && drv_main == '0 && drv_cw == '0 && !active));

  // R5
  frame_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && rep_len != 0) |-> frame < rep_len);

  // R10
  restart_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && start && !stop && !wrap) |=> (active && frame == $past(frame) + 1'b1));
endmodule

// File: tb/us_burst_gen_tb.sv
`timescale 1ns/1ps
module us_burst_gen_tb_top;
  localparam int NCH = 4;
  localparam int HW = 8, PW = 8, QW = 4, RW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, stop = 1'b0;
  logic [RW-1:0]     rep_len;
  logic [NCH*HW-1:0] half_len;
  logic [NCH*PW-1:0] burst_len;
  logic [NCH*QW-1:0] pre_len;
  logic [NCH-1:0]    neg_first, cont_en, two_stage;
  logic [2*NCH-1:0]  drv_pre, drv_main, drv_cw;
  logic              active;

  int hh[NCH], nn[NCH], pp[NCH];
  bit ng[NCH], ct[NCH], tw[NCH];
  int rep;

  int checks = 0, failures = 0;
  logic [23:0] exp_q[$];
  string       tag_q[$];
  logic [23:0] got, want;
  string       tg;

  always #5 clk = ~clk;

  always_comb begin
    rep_len = rep[RW-1:0];
    for (int c = 0; c < NCH; c++) begin
      half_len[c*HW +: HW]  = hh[c][HW-1:0];
      burst_len[c*PW +: PW] = nn[c][PW-1:0];
      pre_len[c*QW +: QW]   = pp[c][QW-1:0];
      neg_first[c] = ng[c];
      cont_en[c]   = ct[c];
      two_stage[c] = tw[c];
    end
  end

  us_burst_gen #(.NCH(NCH), .HW(HW), .PW(PW), .QW(QW), .RW(RW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .rep_len(rep_len),
    .half_len(half_len), .burst_len(burst_len), .pre_len(pre_len),
    .neg_first(neg_first), .cont_en(cont_en), .two_stage(two_stage),
    .drv_pre(drv_pre), .drv_main(drv_main), .drv_cw(drv_cw), .active(active));

  function automatic logic [1:0] pol(bit neg, int k);
    return ((k % 2 == 1) ^ neg) ? 2'b10 : 2'b01;
  endfunction

  function automatic logic [23:0] model(int t);
    logic [7:0] a = '0, b = '0, cc = '0;
    for (int c = 0; c < NCH; c++) begin
      if (ct[c]) cc[2*c +: 2] = pol(ng[c], t / hh[c]);
      else begin
        int f  = t % rep;
        int ap = tw[c] ? pp[c] : 0;
        if (f < ap * hh[c]) a[2*c +: 2] = pol(ng[c], f / hh[c]);
        else begin
          int g = f - ap * hh[c];
          if (g < 2 * nn[c] * hh[c]) b[2*c +: 2] = pol(ng[c], g / hh[c]);
        end
      end
    end
    return {a, b, cc};
  endfunction

  // monitor
  initial forever begin
    @(posedge clk); #1;
    if (exp_q.size() > 0) begin
      want = exp_q.pop_front();
      tg   = tag_q.pop_front();
      got  = {drv_pre, drv_main, drv_cw};
      checks++;
      if (got !== want) begin
        failures++;
        $display("FAIL %s got=%h exp=%h", tg, got, want);
      end
    end
  end

  task automatic drain();
    while (exp_q.size() > 0) @(negedge clk);
  endtask

  task automatic launch(int n, string tag);
    @(negedge clk);
    start = 1'b1;
    for (int t = 0; t < n; t++) begin
      exp_q.push_back(model(t));
      tag_q.push_back(tag);
    end
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic halt(int n, bit with_start, string tag);
    @(negedge clk);
    stop = 1'b1;
    start = with_start;
    for (int t = 0; t < n; t++) begin
      exp_q.push_back(24'h0);
      tag_q.push_back(tag);
    end
    @(negedge clk);
    stop = 1'b0;
    start = 1'b0;
    drain();
  endtask

  task automatic cfg(int c, int h, int n, int p, bit neg, bit cw, bit two);
    hh[c] = h; nn[c] = n; pp[c] = p; ng[c] = neg; ct[c] = cw; tw[c] = two;
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rep = 40;
    cfg(0, 2, 5, 0, 0, 0, 0);
    cfg(1, 2, 5, 0, 1, 0, 0);
    cfg(2, 1, 5, 0, 0, 0, 0);
    cfg(3, 6, 4, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if ({drv_pre, drv_main, drv_cw, active} !== 25'h0) begin
      failures++;
      $display("FAIL R8 reset got=%h exp=0", {drv_pre, drv_main, drv_cw, active});
    end

    // pulsed bursts, counter-phase pair, truncation at frame wrap, restart ignored
    launch(100, "R1 R2 R3 R4 R5 R9 R10 pulsed");
    repeat (40) @(negedge clk);
    start = 1'b1;               // R10: start while running
    @(negedge clk);
    start = 1'b0;
    drain();
    halt(6, 1'b0, "R8 stop");

    // two-stage prelude then burst
    rep = 30;
    cfg(0, 2, 4, 3, 0, 0, 1);
    cfg(1, 2, 4, 3, 1, 0, 1);
    cfg(2, 3, 1, 0, 0, 0, 1);
    cfg(3, 1, 0, 2, 1, 0, 1);
    launch(65, "R6 R9 R11 two-stage");
    drain();
    halt(4, 1'b0, "R8 stop after two-stage");

    // continuous channels next to a pulsed one
    rep = 10;
    cfg(0, 2, 0, 0, 0, 1, 0);
    cfg(1, 2, 0, 0, 1, 1, 0);
    cfg(2, 3, 0, 0, 0, 1, 0);
    cfg(3, 1, 1, 0, 0, 0, 0);
    launch(50, "R7 R9 R11 continuous");
    drain();
    halt(6, 1'b1, "R8 R10 stop wins over start");

    // relaunch after idle with negative-first single pulse
    rep = 12;
    cfg(0, 3, 1, 0, 1, 0, 0);
    cfg(1, 1, 3, 0, 1, 0, 0);
    cfg(2, 2, 2, 1, 0, 0, 1);
    cfg(3, 4, 1, 0, 0, 0, 0);
    launch(30, "R2 R3 R4 relaunch");
    drain();
    halt(3, 1'b0, "R8 final stop");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule